// File: doc/BRIEF.md
# SPI Buffer Descriptor Status Engine

This block owns one receive descriptor and one transmit descriptor for a serial peripheral controller that can act either as bus master or as slave. Software arms a descriptor by writing its ownership bit, interrupt enable, continuous-mode flag and byte length. From then on the engine follows byte-level events from a serial shifter: a byte received, a byte requested, and the shifter going idle. It also watches the select-line level and the master/slave setting, and it decides when each descriptor closes and with which status.

On close, the engine writes a 16-bit status word and a length value through a simple write port. It also emits a one-cycle done pulse, plus an interrupt pulse when the descriptor asked for one. It covers select-line closing in both modes, detection of a collision with another master, receive overrun, transmit underrun, and continuous mode. In continuous mode the receive buffer is never handed back to software and is refilled from its start on every pass.

Top module: `spi_bd_engine`

## Requirements
- R1: After reset the write port is silent (wb_en, rx_done, tx_done, rx_irq, tx_irq all 0) and neither descriptor is owned by the engine.
- R2: A software write (sw_wr, sw_tx selecting 1 = transmit, 0 = receive) loads a descriptor only while its ownership bit is clear. A write to an owned descriptor is ignored, so the descriptor still closes at its previously loaded length.
- R3: Once an owned receive descriptor has accepted as many bytes as its length, it closes. It writes a status word with the ownership bit clear and L clear, and a length field equal to the byte count. rx_done pulses, and rx_irq pulses with it only when the interrupt bit was loaded set.
- R4: In slave mode (cfg_master = 0), a rising edge of sel_n while receive data is in progress closes the receive descriptor with L set and the length equal to the bytes received.
- R5: In master mode, a falling edge of sel_n (another device driving select) closes every active descriptor with ME set. The receive word is written first and the transmit word in the next cycle.
- R6: In master mode, a rising edge of shifter_idle while receiving closes the receive descriptor with L set.
- R7: In slave mode, a byte that arrives while the previous byte has not been acknowledged as stored is dropped and sets OV. In master mode no overrun is flagged and the byte is counted.
- R8: A receive status word is never written while a received byte still awaits its store acknowledge (rx_ack). The write follows that acknowledge.
- R9: With continuous mode loaded, a close in master mode writes the ownership bit as 1 and restarts the byte count, so the next pass closes again at the same length. In slave mode the flag has no effect and ownership is released.
- R10: Each tx_need with tx_avail high counts one byte of the owned transmit descriptor. At the loaded length the descriptor closes with R clear and UN clear, and the length field is the loaded length.
- R11: A tx_need while tx_avail is low closes the transmit descriptor at once with UN set and R clear.
- R12: A received byte with no owned receive descriptor pulses rx_busy one cycle later. A tx_need with no owned transmit descriptor pulses tx_under one cycle later. Neither causes a write.
- R13: Status word layout, written as a 16-bit vector with its index 15 = bit 0 of the word: [15] ownership (E/R), [12] interrupt enable, [11] L, [9] continuous mode, [1] OV (receive) or UN (transmit), [0] ME. All other bits are written as 0, and at most one descriptor is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| sel_n | input | 1 | Select-line level, active low |
| shifter_idle | input | 1 | Shifter has no transfer in progress |
| sw_wr | input | 1 | Software descriptor write strobe |
| sw_tx | input | 1 | Write target: 1 transmit, 0 receive |
| sw_own | input | 1 | Ownership (ready/empty) bit to load |
| sw_irq | input | 1 | Interrupt enable to load |
| sw_cm | input | 1 | Continuous mode to load |
| sw_len | input | LEN_W | Byte length to load |
| rx_byte | input | 1 | Shifter delivered a received byte |
| rx_ack | input | 1 | Last received byte has been stored |
| tx_need | input | 1 | Shifter requests a transmit byte |
| tx_avail | input | 1 | Transmit data available in time |
| wb_en | output | 1 | Status write strobe |
| wb_tx | output | 1 | Write target: 1 transmit, 0 receive |
| wb_status | output | 16 | Status word written back |
| wb_len | output | LEN_W | Length field written back |
| rx_done | output | 1 | Receive descriptor closed |
| tx_done | output | 1 | Transmit descriptor closed |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_busy | output | 1 | Byte arrived with no receive descriptor |
| tx_under | output | 1 | Byte requested with no transmit descriptor |

## Verification
Buffer-full closes are tried with random lengths and random interrupt enables, in both directions. This separates a correct count-to-length compare from off-by-one errors and from mixed-up interrupt gating. Directed patterns then give each closing cause its own stimulus: select negation in slave mode, select assertion in master mode, a rising idle edge, an unavailable transmit byte, and a second byte arriving before the first was stored. Each cause therefore shows up as a distinct set of L, OV, UN and ME bits. Continuous mode is run for two passes in master mode and then a third in slave mode, which shows whether ownership is kept or released according to the mode at close time.

// File: rtl/spi_bd_pkg.sv
package spi_bd_pkg;

  localparam int STW = 16;

  // vector index of each field (word bit 0 sits at index 15)
  localparam int B_OWN = 15;
  localparam int B_INT = 12;
  localparam int B_LST = 11;
  localparam int B_CNT = 9;
  localparam int B_ERR = 1;
  localparam int B_MME = 0;

  localparam logic [STW-1:0] RSV_MASK = ~((STW'(1) << B_OWN) | (STW'(1) << B_INT) |
                                          (STW'(1) << B_LST) | (STW'(1) << B_CNT) |
                                          (STW'(1) << B_ERR) | (STW'(1) << B_MME));

  function automatic logic [STW-1:0] pack_status(input logic own, input logic ien,
                                                 input logic lst, input logic cnt,
                                                 input logic err, input logic mme);
    logic [STW-1:0] w;
    w        = '0;
    w[B_OWN] = own;
    w[B_INT] = ien;
    w[B_LST] = lst;
    w[B_CNT] = cnt;
    w[B_ERR] = err;
    w[B_MME] = mme;
    return w;
  endfunction

endpackage

// File: rtl/spi_bd_rx.sv
module spi_bd_rx
  import spi_bd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             master,
  input  logic             sw_ld,
  input  logic             sw_own,
  input  logic             sw_irq,
  input  logic             sw_cm,
  input  logic [LEN_W-1:0] sw_len,
  input  logic             rx_byte,
  input  logic             rx_ack,
  input  logic             sel_rise,
  input  logic             sel_fall,
  input  logic             idle_rise,
  input  logic             grant,
  output logic             req,
  output logic             irq_en,
  output logic [STW-1:0]   status,
  output logic [LEN_W-1:0] len_out,
  output logic             pend,
  output logic             busy
);

  logic own_q, own_d, ien_q, ien_d, cm_q, cm_d, act_q, act_d;
  logic ov_q, ov_d, pend_q, pend_d, cls_q, cls_d, lst_q, lst_d, me_q, me_d;
  logic busy_q, busy_d;
  logic [LEN_W-1:0] max_q, max_d, cnt_q, cnt_d, cnt_inc;
  logic open_ok, ovr_hit, take, active_now, cm_eff;

  assign cnt_inc    = cnt_q + LEN_W'(1);
  assign open_ok    = own_q & ~cls_q;
  assign ovr_hit    = rx_byte & open_ok & ~master & pend_q & ~rx_ack;
  assign take       = rx_byte & open_ok & ~ovr_hit;
  assign active_now = act_q | take;
  assign cm_eff     = cm_q & master;

  always_comb begin
    own_d  = own_q;  ien_d = ien_q;  cm_d  = cm_q;  max_d = max_q;
    cnt_d  = cnt_q;  act_d = act_q;  ov_d  = ov_q;  cls_d = cls_q;
    lst_d  = lst_q;  me_d  = me_q;
    busy_d = rx_byte & ~open_ok;
    pend_d = take ? 1'b1 : (rx_ack ? 1'b0 : pend_q);
    if (grant) begin
      own_d = cm_eff;
      cnt_d = '0;
      act_d = 1'b0;
      ov_d  = 1'b0;
      cls_d = 1'b0;
      lst_d = 1'b0;
      me_d  = 1'b0;
    end else begin
      if (sw_ld && !own_q) begin
        own_d = sw_own;
        ien_d = sw_irq;
        cm_d  = sw_cm;
        max_d = sw_len;
        cnt_d = '0;
        act_d = 1'b0;
        ov_d  = 1'b0;
      end
      if (ovr_hit) ov_d = 1'b1;
      if (take) begin
        cnt_d = cnt_inc;
        act_d = 1'b1;
        if (cnt_inc == max_q) cls_d = 1'b1;
      end
      if (open_ok && active_now) begin
        if (!master && sel_rise) begin
          cls_d = 1'b1;
          lst_d = 1'b1;
        end
        if (master && idle_rise) begin
          cls_d = 1'b1;
          lst_d = 1'b1;
        end
        if (master && sel_fall) begin
          cls_d = 1'b1;
          me_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= 1'b0; ien_q <= 1'b0; cm_q <= 1'b0; max_q <= '0;
      cnt_q <= '0;   act_q <= 1'b0; ov_q <= 1'b0; pend_q <= 1'b0;
      cls_q <= 1'b0; lst_q <= 1'b0; me_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      own_q <= own_d; ien_q <= ien_d; cm_q <= cm_d; max_q <= max_d;
      cnt_q <= cnt_d; act_q <= act_d; ov_q <= ov_d; pend_q <= pend_d;
      cls_q <= cls_d; lst_q <= lst_d; me_q <= me_d; busy_q <= busy_d;
    end
  end

  assign req     = cls_q & ~pend_q;
  assign irq_en  = ien_q;
  assign status  = pack_status(cm_eff, ien_q, lst_q, cm_q, ov_q, me_q);
  assign len_out = cnt_q;
  assign pend    = pend_q;
  assign busy    = busy_q;

endmodule

// File: rtl/spi_bd_tx.sv
module spi_bd_tx
  import spi_bd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             master,
  input  logic             sw_ld,
  input  logic             sw_own,
  input  logic             sw_irq,
  input  logic             sw_cm,
  input  logic [LEN_W-1:0] sw_len,
  input  logic             tx_need,
  input  logic             tx_avail,
  input  logic             sel_fall,
  input  logic             grant,
  output logic             req,
  output logic             irq_en,
  output logic [STW-1:0]   status,
  output logic [LEN_W-1:0] len_out,
  output logic             under
);

  logic own_q, own_d, ien_q, ien_d, cm_q, cm_d, act_q, act_d;
  logic un_q, un_d, cls_q, cls_d, me_q, me_d, und_q, und_d;
  logic [LEN_W-1:0] max_q, max_d, cnt_q, cnt_d, cnt_inc;
  logic open_ok, need_ok, cm_eff;

  assign cnt_inc = cnt_q + LEN_W'(1);
  assign open_ok = own_q & ~cls_q;
  assign need_ok = tx_need & open_ok;
  assign cm_eff  = cm_q & master;

  always_comb begin
    own_d = own_q; ien_d = ien_q; cm_d = cm_q; max_d = max_q;
    cnt_d = cnt_q; act_d = act_q; un_d = un_q; cls_d = cls_q; me_d = me_q;
    und_d = tx_need & ~open_ok;
    if (grant) begin
      own_d = cm_eff;
      cnt_d = '0;
      act_d = 1'b0;
      un_d  = 1'b0;
      cls_d = 1'b0;
      me_d  = 1'b0;
    end else begin
      if (sw_ld && !own_q) begin
        own_d = sw_own;
        ien_d = sw_irq;
        cm_d  = sw_cm;
        max_d = sw_len;
        cnt_d = '0;
        act_d = 1'b0;
      end
      if (need_ok) begin
        act_d = 1'b1;
        if (!tx_avail) begin
          un_d  = 1'b1;
          cls_d = 1'b1;
        end else begin
          cnt_d = cnt_inc;
          if (cnt_inc == max_q) cls_d = 1'b1;
        end
      end
      if (open_ok && master && sel_fall && (act_q || need_ok)) begin
        cls_d = 1'b1;
        me_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= 1'b0; ien_q <= 1'b0; cm_q <= 1'b0; max_q <= '0;
      cnt_q <= '0;   act_q <= 1'b0; un_q <= 1'b0; cls_q <= 1'b0;
      me_q  <= 1'b0; und_q <= 1'b0;
    end else begin
      own_q <= own_d; ien_q <= ien_d; cm_q <= cm_d; max_q <= max_d;
      cnt_q <= cnt_d; act_q <= act_d; un_q <= un_d; cls_q <= cls_d;
      me_q  <= me_d;  und_q <= und_d;
    end
  end

  assign req     = cls_q;
  assign irq_en  = ien_q;
  assign status  = pack_status(cm_eff, ien_q, 1'b0, cm_q, un_q, me_q);
  assign len_out = max_q;
  assign under   = und_q;

endmodule

// File: rtl/spi_bd_wb.sv
module spi_bd_wb
  import spi_bd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             rx_req,
  input  logic             rx_ien,
  input  logic [STW-1:0]   rx_status,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_req,
  input  logic             tx_ien,
  input  logic [STW-1:0]   tx_status,
  input  logic [LEN_W-1:0] tx_len,
  output logic             rx_grant,
  output logic             tx_grant,
  output logic             wb_en,
  output logic             wb_tx,
  output logic [STW-1:0]   wb_status,
  output logic [LEN_W-1:0] wb_len,
  output logic             rx_done,
  output logic             tx_done,
  output logic             rx_irq,
  output logic             tx_irq
);

  logic             en_d, tx_d, rxd_d, txd_d, rxi_d, txi_d;
  logic [STW-1:0]   st_d;
  logic [LEN_W-1:0] len_d;

  // receive side wins a simultaneous close
  assign rx_grant = rx_req;
  assign tx_grant = tx_req & ~rx_req;

  always_comb begin
    en_d  = rx_grant | tx_grant;
    tx_d  = tx_grant;
    st_d  = rx_grant ? rx_status : (tx_grant ? tx_status : '0);
    len_d = rx_grant ? rx_len    : (tx_grant ? tx_len    : '0);
    rxd_d = rx_grant;
    txd_d = tx_grant;
    rxi_d = rx_grant & rx_ien;
    txi_d = tx_grant & tx_ien;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en   <= 1'b0; wb_tx   <= 1'b0; wb_status <= '0; wb_len <= '0;
      rx_done <= 1'b0; tx_done <= 1'b0; rx_irq    <= 1'b0; tx_irq <= 1'b0;
    end else begin
      wb_en   <= en_d;  wb_tx   <= tx_d;  wb_status <= st_d;  wb_len <= len_d;
      rx_done <= rxd_d; tx_done <= txd_d; rx_irq    <= rxi_d; tx_irq <= txi_d;
    end
  end

endmodule

// File: rtl/spi_bd_engine.sv
module spi_bd_engine
  import spi_bd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             sel_n,
  input  logic             shifter_idle,
  input  logic             sw_wr,
  input  logic             sw_tx,
  input  logic             sw_own,
  input  logic             sw_irq,
  input  logic             sw_cm,
  input  logic [LEN_W-1:0] sw_len,
  input  logic             rx_byte,
  input  logic             rx_ack,
  input  logic             tx_need,
  input  logic             tx_avail,
  output logic             wb_en,
  output logic             wb_tx,
  output logic [STW-1:0]   wb_status,
  output logic [LEN_W-1:0] wb_len,
  output logic             rx_done,
  output logic             tx_done,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             rx_busy,
  output logic             tx_under
);

  logic [1:0]       rst_sync_q, rst_sync_d;
  logic             rst_ni;
  logic             sel_q, sel_d, idle_q, idle_d;
  logic             sel_rise, sel_fall, idle_rise;
  logic             rx_req, rx_ien, rx_grant, rx_pend;
  logic             tx_req, tx_ien, tx_grant;
  logic [STW-1:0]   rx_status, tx_status;
  logic [LEN_W-1:0] rx_len, tx_len;

  // asynchronous assertion, synchronous release
  assign rst_sync_d = {rst_sync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= rst_sync_d;
  end
  assign rst_ni = rst_sync_q[1];

  assign sel_d  = sel_n;
  assign idle_d = shifter_idle;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b1;
      idle_q <= 1'b1;
    end else begin
      sel_q  <= sel_d;
      idle_q <= idle_d;
    end
  end
  assign sel_rise  = sel_n & ~sel_q;
  assign sel_fall  = ~sel_n & sel_q;
  assign idle_rise = shifter_idle & ~idle_q;

  spi_bd_rx #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_ni(rst_ni), .master(cfg_master),
    .sw_ld(sw_wr & ~sw_tx), .sw_own(sw_own), .sw_irq(sw_irq), .sw_cm(sw_cm),
    .sw_len(sw_len), .rx_byte(rx_byte), .rx_ack(rx_ack),
    .sel_rise(sel_rise), .sel_fall(sel_fall), .idle_rise(idle_rise),
    .grant(rx_grant), .req(rx_req), .irq_en(rx_ien), .status(rx_status),
    .len_out(rx_len), .pend(rx_pend), .busy(rx_busy)
  );

  spi_bd_tx #(.LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_ni(rst_ni), .master(cfg_master),
    .sw_ld(sw_wr & sw_tx), .sw_own(sw_own), .sw_irq(sw_irq), .sw_cm(sw_cm),
    .sw_len(sw_len), .tx_need(tx_need), .tx_avail(tx_avail),
    .sel_fall(sel_fall), .grant(tx_grant), .req(tx_req), .irq_en(tx_ien),
    .status(tx_status), .len_out(tx_len), .under(tx_under)
  );

  spi_bd_wb #(.LEN_W(LEN_W)) u_wb (
    .clk(clk), .rst_ni(rst_ni),
    .rx_req(rx_req), .rx_ien(rx_ien), .rx_status(rx_status), .rx_len(rx_len),
    .tx_req(tx_req), .tx_ien(tx_ien), .tx_status(tx_status), .tx_len(tx_len),
    .rx_grant(rx_grant), .tx_grant(tx_grant),
    .wb_en(wb_en), .wb_tx(wb_tx), .wb_status(wb_status), .wb_len(wb_len),
    .rx_done(rx_done), .tx_done(tx_done), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

endmodule

// File: rtl/spi_bd_engine_chk.sv
module spi_bd_engine_chk
  import spi_bd_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_master,
  input logic           wb_en,
  input logic           wb_tx,
  input logic [STW-1:0] wb_status,
  input logic           rx_done,
  input logic           tx_done,
  input logic           rx_irq,
  input logic           tx_irq,
  input logic           rx_pend
);

  p_one_close_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_done, tx_done}));

  p_rx_irq_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_done);

  p_tx_irq_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_done);

  p_after_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wb_tx) |-> !rx_pend);

  p_slave_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wb_tx && !$past(cfg_master)) |-> !wb_status[B_OWN]);

  p_rsv_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ((wb_status & RSV_MASK) == '0));

endmodule

bind spi_bd_engine spi_bd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .cfg_master(cfg_master), .wb_en(wb_en),
  .wb_tx(wb_tx), .wb_status(wb_status), .rx_done(rx_done), .tx_done(tx_done),
  .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_pend(rx_pend)
);

// File: tb/spi_bd_engine_tb.sv
`timescale 1ns/1ps
module spi_bd_engine_tb;

  localparam int LW = 16;

  logic clk, rst_n, cfg_master, sel_n, shifter_idle;
  logic sw_wr, sw_tx, sw_own, sw_irq, sw_cm;
  logic [LW-1:0] sw_len;
  logic rx_byte, rx_ack, tx_need, tx_avail;
  logic wb_en, wb_tx, rx_done, tx_done, rx_irq, tx_irq, rx_busy, tx_under;
  logic [15:0] wb_status;
  logic [LW-1:0] wb_len;

  int n_chk = 0, n_bad = 0, wb_cnt = 0, busy_cnt = 0, und_cnt = 0;
  logic [15:0] last_st, prev_st;
  logic [LW-1:0] last_len, prev_len;
  logic last_tx, prev_tx, last_irq;
  bit done = 0;

  spi_bd_engine #(.LEN_W(LW)) u_dut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (wb_en) begin
      prev_st = last_st; prev_len = last_len; prev_tx = last_tx;
      last_st = wb_status; last_len = wb_len; last_tx = wb_tx;
      last_irq = rx_irq | tx_irq;
      wb_cnt++;
    end
    if (rx_busy) busy_cnt++;
    if (tx_under) und_cnt++;
  end

  function automatic logic [15:0] xst(bit own, bit ien, bit lst, bit cm, bit err, bit me);
    return {own, 2'b00, ien, lst, 1'b0, cm, 7'b0, err, me};
  endfunction

  task automatic chk(string req, longint got, longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load(bit tx, bit own, bit irq, bit cm, int len);
    sw_wr = 1; sw_tx = tx; sw_own = own; sw_irq = irq; sw_cm = cm; sw_len = LW'(len);
    tick();
    sw_wr = 0;
  endtask

  task automatic rx_one(bit ack);
    rx_byte = 1; tick(); rx_byte = 0;
    if (ack) begin rx_ack = 1; tick(); rx_ack = 0; end
  endtask

  task automatic need(bit avail);
    tx_need = 1; tx_avail = avail; tick(); tx_need = 0; tx_avail = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, lenr, irqr;
    void'($urandom(32'd2024));
    rst_n = 0; cfg_master = 1; sel_n = 1; shifter_idle = 1;
    sw_wr = 0; sw_tx = 0; sw_own = 0; sw_irq = 0; sw_cm = 0; sw_len = '0;
    rx_byte = 0; rx_ack = 0; tx_need = 0; tx_avail = 1;
    tick(3); rst_n = 1; tick(4);

    // R1 reset state
    chk("R1 wb_en", wb_en, 0);
    chk("R1 done/irq", {rx_done, tx_done, rx_irq, tx_irq}, 0);

    // R12 events with nothing owned
    rx_one(0); need(1); tick(3);
    chk("R12 busy", busy_cnt, 1);
    chk("R12 under", und_cnt, 1);
    chk("R12 no write", wb_cnt, 0);
    rx_ack = 1; tick(); rx_ack = 0;

    // R2 write while owned is ignored
    load(0, 1, 0, 0, 2);
    load(0, 1, 1, 0, 5);
    w0 = wb_cnt;
    rx_one(1); rx_one(1); tick(4);
    chk("R2 closed at old length", wb_cnt - w0, 1);
    chk("R2 len", last_len, 2);
    chk("R2 status", last_st, xst(0, 0, 0, 0, 0, 0));

    // R3 random receive lengths (master mode)
    for (int i = 0; i < 6; i++) begin
      lenr = 1 + $urandom % 10; irqr = $urandom % 2;
      load(0, 1, irqr[0], 0, lenr);
      w0 = wb_cnt;
      for (int b = 0; b < lenr; b++) rx_one(1);
      tick(4);
      chk("R3 one write", wb_cnt - w0, 1);
      chk("R3 len", last_len, lenr);
      chk("R3 status", last_st, xst(0, irqr[0], 0, 0, 0, 0));
      chk("R3 irq", last_irq, irqr[0]);
      chk("R13 target rx", last_tx, 0);
    end

    // R10 random transmit lengths
    for (int i = 0; i < 6; i++) begin
      lenr = 1 + $urandom % 12; irqr = $urandom % 2;
      load(1, 1, irqr[0], 0, lenr);
      w0 = wb_cnt;
      for (int b = 0; b < lenr; b++) need(1);
      tick(4);
      chk("R10 one write", wb_cnt - w0, 1);
      chk("R10 len", last_len, lenr);
      chk("R10 status", last_st, xst(0, irqr[0], 0, 0, 0, 0));
      chk("R10 irq", last_irq, irqr[0]);
      chk("R13 target tx", last_tx, 1);
    end

    // R11 underrun
    load(1, 1, 0, 0, 4);
    need(1); need(0); tick(4);
    chk("R11 status", last_st, xst(0, 0, 0, 0, 1, 0));
    chk("R11 len", last_len, 4);

    // R7 slave overrun
    cfg_master = 0; tick();
    load(0, 1, 0, 0, 10);
    sel_n = 0; tick();
    rx_one(0); rx_one(0);
    rx_ack = 1; tick(); rx_ack = 0;
    w0 = wb_cnt;
    sel_n = 1; tick(4);
    chk("R7 write", wb_cnt - w0, 1);
    chk("R7 status", last_st, xst(0, 0, 1, 0, 1, 0));
    chk("R7 len", last_len, 1);

    // R8 write waits for store acknowledge
    load(0, 1, 0, 0, 10);
    sel_n = 0; tick();
    rx_one(0);
    w0 = wb_cnt;
    sel_n = 1; tick(6);
    chk("R8 held", wb_cnt - w0, 0);
    rx_ack = 1; tick(); rx_ack = 0; tick(3);
    chk("R8 after ack", wb_cnt - w0, 1);
    chk("R8 status", last_st, xst(0, 0, 1, 0, 0, 0));

    // R4 slave select negation
    load(0, 1, 1, 0, 10);
    sel_n = 0; tick();
    rx_one(1); rx_one(1);
    sel_n = 1; tick(4);
    chk("R4 status", last_st, xst(0, 1, 1, 0, 0, 0));
    chk("R4 len", last_len, 2);
    chk("R4 irq", last_irq, 1);

    // R5 master collision
    cfg_master = 1; tick();
    load(0, 1, 0, 0, 8); load(1, 1, 0, 0, 4);
    rx_one(1); need(1);
    w0 = wb_cnt;
    sel_n = 0; tick(5); sel_n = 1; tick();
    chk("R5 two writes", wb_cnt - w0, 2);
    chk("R5 rx first", {prev_tx, last_tx}, 2'b01);
    chk("R5 rx status", prev_st, xst(0, 0, 0, 0, 0, 1));
    chk("R5 rx len", prev_len, 1);
    chk("R5 tx status", last_st, xst(0, 0, 0, 0, 0, 1));

    // R6 idle edge, master: no overrun flagged (R7)
    load(0, 1, 0, 0, 10);
    shifter_idle = 0; tick();
    rx_one(0); rx_one(0);
    rx_ack = 1; tick(); rx_ack = 0;
    shifter_idle = 1; tick(4);
    chk("R6 status", last_st, xst(0, 0, 1, 0, 0, 0));
    chk("R7 master count", last_len, 2);

    // R9 continuous mode
    load(0, 1, 0, 1, 3);
    w0 = wb_cnt;
    for (int b = 0; b < 3; b++) rx_one(1);
    tick(4);
    chk("R9 keep own", last_st, xst(1, 0, 0, 1, 0, 0));
    chk("R9 len", last_len, 3);
    load(0, 1, 0, 0, 9);
    for (int b = 0; b < 3; b++) rx_one(1);
    tick(4);
    chk("R9 second pass", wb_cnt - w0, 2);
    chk("R9 second status", last_st, xst(1, 0, 0, 1, 0, 0));
    cfg_master = 0; tick();
    for (int b = 0; b < 3; b++) rx_one(1);
    tick(4);
    chk("R9 slave releases", last_st, xst(0, 0, 0, 1, 0, 0));
    chk("R9 slave len", last_len, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule